// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. Software selects a clock divisor and a 16-bit reload count, enables counting, and from then on must keep proving that it is alive. The proof is a write to a refresh register in which one or more 2-bit codes swap between the values 1 and 2. Each code has its own action: one reloads the down-counter, one moves a staged divisor into the running prescaler, and one clears the timeout interrupt.

All writes go through a single-cycle register port. A write counts only if its upper half-word holds the unlock key 0x1234. The lower half-word carries the data. If the counter runs down to zero while enabled, the block latches an interrupt and issues a one-cycle reset request. It then reloads itself and keeps counting.

Top module: `keyed_wdt`

## Requirements
- R1: A write takes effect only when bus_wdata[31:16] equals 0x1234. A write with any other upper half leaves every register unchanged, refresh codes included.
- R2: After reset the registers read as follows: config 0x0000_0F00 (divisor 16), reload 0x0000_FFFF, enable 0, refresh 0x0000_0015. Both outputs are low.
- R3: The register offsets are config 0x04, reload 0x08, refresh 0x18 and enable 0x1C.
  - Config keeps only bits 15:8, which hold the divisor minus one.
  - Reload keeps bits 15:0.
  - Enable keeps bit 0.
  - Every read returns zeros in the bits that are not kept.
- R4: The refresh register holds three groups: bits 5:4 apply the config, bits 3:2 reload the counter, and bits 1:0 clear the interrupt. A group acts once, and stores the new code, only when it is written with 1 or 2 and that value differs from its stored code. A rewrite of the same code, or a write of 0 or 3, does nothing.
- R5: A counter-reload action restarts the prescaler and the counter. With reload value L and divisor D, the reset request then pulses (L+1)*D cycles after the write edge.
- R6: A config write only stages the divisor. The prescaler keeps its old divisor until a config-apply action.
- R7: While the enable bit is 0, the counter and prescaler hold, and no timeout occurs.
- R8: On timeout, the interrupt goes high and stays high. The reset request goes high for one cycle. The counter reloads, so the next timeout follows after another (L+1)*D cycles.
- R9: An interrupt-clear action drops the interrupt at the write edge.
- R10: Reads of offsets that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: key in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_timeout | output | 1 | Sticky timeout interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Most internal faults appear as a shift in the cycle at which rst_req pulses. A stuck prescaler, a counter that misses a reload, or a divisor applied too early all move that pulse. The bench measures the distance from the refresh write to the pulse exactly, so one slip is seen within one timeout period. Faults in the key check or the change detector appear at once in the register readback. A reload that should have been ignored instead pushes the next pulse later by a known number of cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [15:0] WR_KEY     = 16'h1234;
    localparam logic [7:0]  OFF_CFG    = 8'h04;
    localparam logic [7:0]  OFF_LOAD   = 8'h08;
    localparam logic [7:0]  OFF_KICK   = 8'h18;
    localparam logic [7:0]  OFF_START  = 8'h1C;
    localparam int          CFG_LSB    = 8;
    localparam int          KICK_GROUPS = 3;
    localparam logic [1:0]  CODE_RST   = 2'd1;

    // one strobe per refresh group; packed order puts group 2 at the msb
    typedef struct packed {
        logic cfg;
        logic cnt;
        logic irq;
    } kick_t;

    function automatic logic code_legal(input logic [1:0] c);
        return (c == 2'd1) || (c == 2'd2);
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 16,
    parameter logic [DIV_W-1:0] DIV_RST  = 8'd15,
    parameter logic [CNT_W-1:0] LOAD_RST = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [DIV_W-1:0]  div_stage,
    output logic [CNT_W-1:0]  load_val,
    output logic              cnt_en,
    output logic [2*KICK_GROUPS-1:0] codes,
    output kick_t             kick
);
    localparam int CODES_W = 2 * KICK_GROUPS;

    logic keyed, kick_wr;
    logic [KICK_GROUPS-1:0] hit;
    logic [CODES_W-1:0]     codes_nx;

    assign keyed   = we && (wdata[31:16] == WR_KEY);
    assign kick_wr = keyed && (addr == ADDR_W'(OFF_KICK));

    for (genvar g = 0; g < KICK_GROUPS; g++) begin : g_grp
        logic [1:0] wr_c, cur_c;
        assign wr_c  = wdata[2*g+1 -: 2];
        assign cur_c = codes[2*g+1 -: 2];
        assign hit[g] = kick_wr && code_legal(wr_c) && (wr_c != cur_c);
        assign codes_nx[2*g+1 -: 2] = hit[g] ? wr_c : cur_c;
    end

    assign kick = kick_t'(hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_stage <= DIV_RST;
            load_val  <= LOAD_RST;
            cnt_en    <= 1'b0;
            codes     <= {KICK_GROUPS{CODE_RST}};
        end else if (keyed) begin
            if (addr == ADDR_W'(OFF_CFG))   div_stage <= wdata[CFG_LSB +: DIV_W];
            if (addr == ADDR_W'(OFF_LOAD))  load_val  <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(OFF_START)) cnt_en    <= wdata[0];
            if (addr == ADDR_W'(OFF_KICK))  codes     <= codes_nx;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CFG))        rdata[CFG_LSB +: DIV_W] = div_stage;
        else if (addr == ADDR_W'(OFF_LOAD))  rdata[CNT_W-1:0] = load_val;
        else if (addr == ADDR_W'(OFF_START)) rdata[0] = cnt_en;
        else if (addr == ADDR_W'(OFF_KICK))  rdata[CODES_W-1:0] = codes;
    end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV_W = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 8'd15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             apply_cfg,
    input  logic [DIV_W-1:0] div_stage,
    output logic             tick
);
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] pcnt;
    logic             at_end;

    // >= keeps the count bounded when a smaller divisor is applied mid-count
    assign at_end = (pcnt >= act_div);
    assign tick   = en && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_div <= DIV_RST;
            pcnt    <= '0;
        end else begin
            if (apply_cfg) act_div <= div_stage;
            if (!en || restart || at_end) pcnt <= '0;
            else                          pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] LOAD_RST = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic             clr_irq,
    input  logic [CNT_W-1:0] load_val,
    output logic             irq_timeout,
    output logic             rst_req
);
    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = tick && !reload && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= LOAD_RST;
            irq_timeout <= 1'b0;
            rst_req     <= 1'b0;
        end else begin
            rst_req <= expire;
            if (reload)             cnt <= load_val;
            else if (expire)        cnt <= load_val;
            else if (tick)          cnt <= cnt - 1'b1;
            if (expire)             irq_timeout <= 1'b1;
            else if (clr_irq)       irq_timeout <= 1'b0;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_timeout,
    output logic              rst_req
);
    localparam logic [DIV_W-1:0] DIV_RST  = DIV_W'(15);
    localparam logic [CNT_W-1:0] LOAD_RST = '1;

    logic [DIV_W-1:0]         div_stage;
    logic [CNT_W-1:0]         load_val;
    logic                     cnt_en;
    logic [2*KICK_GROUPS-1:0] codes;
    kick_t                    kick;
    logic                     tick;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W),
        .DIV_RST(DIV_RST), .LOAD_RST(LOAD_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .rdata(bus_rdata), .div_stage(div_stage), .load_val(load_val),
        .cnt_en(cnt_en), .codes(codes), .kick(kick)
    );

    wdt_prescale #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_pre (
        .clk(clk), .rst(rst), .en(cnt_en), .restart(kick.cnt),
        .apply_cfg(kick.cfg), .div_stage(div_stage), .tick(tick)
    );

    wdt_downcnt #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .reload(kick.cnt),
        .clr_irq(kick.irq), .load_val(load_val),
        .irq_timeout(irq_timeout), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic             cnt_en,
    input logic [CNT_W-1:0] load_val,
    input logic [5:0]       codes,
    input kick_t            kick,
    input logic             irq_timeout,
    input logic             rst_req
);
    a_r1_key_guard: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_wdata[31:16] != WR_KEY) |=>
            ($stable(load_val) && $stable(cnt_en) && $stable(codes)));

    a_r4_codes_legal: assert property (@(posedge clk) disable iff (rst)
        code_legal(codes[1:0]) && code_legal(codes[3:2]) && code_legal(codes[5:4]));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> !rst_req);

    a_r8_pulse_with_irq: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> irq_timeout);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_timeout && !kick.irq) |=> irq_timeout);

    a_r9_rise_from_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_timeout) |-> rst_req);
endmodule

bind keyed_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .cnt_en(cnt_en), .load_val(load_val), .codes(codes), .kick(kick),
    .irq_timeout(irq_timeout), .rst_req(rst_req)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_timeout, rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_cfg, m_load, m_start, m_codes;

    keyed_wdt dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_timeout(irq_timeout), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks are entered and left at a negedge
    task automatic wr(input logic [7:0] a, input logic [15:0] key, input logic [15:0] d);
        bus_addr = a; bus_wdata = {key, d}; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req) begin n = i; break; end
        end
    endtask

    // expected codes after a keyed refresh write, per the change rule
    function automatic logic [31:0] next_codes(input logic [31:0] cur, input logic [5:0] w);
        logic [31:0] r = cur;
        for (int g = 0; g < 3; g++) begin
            logic [1:0] c = w[2*g +: 2];
            if ((c == 2'd1 || c == 2'd2) && c != cur[2*g +: 2]) r[2*g +: 2] = c;
        end
        return r;
    endfunction

    function automatic int period(input int load, input int div);
        return (load + 1) * div;
    endfunction

    initial begin
        logic [31:0] v;
        int n;
        int unsigned seed;
        seed = $urandom(32'd2024);
        m_cfg = 32'h0F00; m_load = 32'hFFFF; m_start = 0; m_codes = 32'h15;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2 reset state
        rd(8'h04, v); check("R2 cfg", v, m_cfg);
        rd(8'h08, v); check("R2 load", v, m_load);
        rd(8'h1C, v); check("R2 start", v, m_start);
        rd(8'h18, v); check("R2 codes", v, m_codes);
        check("R2 outputs", {30'b0, irq_timeout, rst_req}, 32'h0);

        // R1 / R3 random keyed and unkeyed writes with readback
        for (int i = 0; i < 40; i++) begin
            logic [7:0]  a;
            logic [15:0] key, d;
            bit ok;
            a   = ($urandom % 2) ? 8'h04 : 8'h08;
            ok  = ($urandom % 2) == 1;
            d   = 16'($urandom);
            key = ok ? 16'h1234 : (16'h1234 ^ 16'(($urandom % 65535) + 1));
            wr(a, key, d);
            if (ok && a == 8'h04) m_cfg  = {16'h0, d[15:8], 8'h0};
            if (ok && a == 8'h08) m_load = {16'h0, d};
            rd(8'h04, v); check("R1 R3 cfg readback", v, m_cfg);
            rd(8'h08, v); check("R1 R3 load readback", v, m_load);
        end
        wr(8'h1C, 16'hABCD, 16'hFFFF);
        rd(8'h1C, v); check("R1 start unkeyed", v, 32'h0);

        // R10 unmapped
        rd(8'h00, v); check("R10 off 00", v, 32'h0);
        rd(8'h10, v); check("R10 off 10", v, 32'h0);

        // R4 code detector readback
        wr(8'h18, 16'h1234, 16'hFF2A); m_codes = next_codes(m_codes, 6'h2A);
        rd(8'h18, v); check("R4 toggle to 2", v, m_codes);
        check("R4 model", m_codes, 32'h2A);
        wr(8'h18, 16'h1234, 16'h003F);
        rd(8'h18, v); check("R4 code 3 ignored", v, 32'h2A);
        wr(8'h18, 16'h1234, 16'h0000);
        rd(8'h18, v); check("R4 code 0 ignored", v, 32'h2A);
        wr(8'h18, 16'h4321, 16'h0015);
        rd(8'h18, v); check("R1 refresh unkeyed", v, 32'h2A);

        // R5 period with load 3, divisor 2
        wr(8'h04, 16'h1234, 16'h0100);
        wr(8'h08, 16'h1234, 16'h0003);
        wr(8'h1C, 16'h1234, 16'h0001);
        rd(8'h1C, v); check("R3 start bit", v, 32'h1);
        wr(8'h18, 16'h1234, 16'h0015); m_codes = 32'h15;
        wait_pulse(200, n); check("R5 first timeout", n, period(3, 2));
        check("R8 irq set", irq_timeout, 1'b1);
        step(1);
        check("R8 pulse one cycle", rst_req, 1'b0);
        check("R8 irq sticky", irq_timeout, 1'b1);
        wait_pulse(200, n); check("R8 auto reload period", n + 1, period(3, 2));

        // R6 staged divisor
        wr(8'h04, 16'h1234, 16'h0300);
        wr(8'h18, 16'h1234, 16'h0019); m_codes = next_codes(m_codes, 6'h19);
        wait_pulse(200, n); check("R6 old divisor kept", n, period(3, 2));
        wr(8'h18, 16'h1234, 16'h0025); m_codes = next_codes(m_codes, 6'h25);
        wait_pulse(200, n); check("R6 divisor applied", n, period(3, 4));
        rd(8'h18, v); check("R4 codes model", v, m_codes);

        // R4 same-code rewrite must not reload
        wr(8'h18, 16'h1234, 16'h0029); m_codes = next_codes(m_codes, 6'h29);
        step(3);
        wr(8'h18, 16'h1234, 16'h0029);
        wait_pulse(200, n); check("R4 same code no reload", n + 4, period(3, 4));

        // R9 interrupt clear
        check("R9 irq before clear", irq_timeout, 1'b1);
        wr(8'h18, 16'h1234, 16'h002A); m_codes = next_codes(m_codes, 6'h2A);
        check("R9 irq cleared", irq_timeout, 1'b0);
        rd(8'h18, v); check("R9 codes", v, m_codes);

        // R7 disabled holds
        wr(8'h1C, 16'h1234, 16'h0000);
        wait_pulse(80, n); check("R7 no timeout when off", n, -1);
        check("R7 irq stays low", irq_timeout, 1'b0);
        wr(8'h1C, 16'h1234, 16'h0001);
        wait_pulse(80, n); check("R7 resumes", (n > 0 && n <= period(3, 4)), 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule